// File: doc/BRIEF.md
# Four-Quadrant Banked Register File with Shared Crossbar

This block holds the architectural registers of four side-by-side function-unit lanes. The storage is cut into four quadrants, one per lane. A register lives in the quadrant named by the two low bits of its number, and the remaining upper bits pick the entry inside that quadrant. As a result, four consecutively numbered registers fall into four different quadrants. Each lane owns three read ports and one write port on its own quadrant. Work that stays inside the lane's own quadrant never waits.

A lane can also reach a register held by another quadrant, but only through one shared crossbar. The crossbar moves at most one word into or out of each destination quadrant per cycle. Competing remote accesses aimed at the same quadrant are resolved by a round-robin arbiter. A lane that loses sees its ready held low and keeps its request up until it wins.

Read results come back on a registered response port, one cycle after acceptance for a local read and two cycles after acceptance for a remote read. A read that is accepted in the same cycle as a write to the same register returns the value being written.

Top module: `qbank_rf`

## Requirements
- R1: A register number splits so that bits [1:0] select the quadrant and bits [AW-1:2] select the entry inside it. After reset every register reads as zero and no response is valid.
- R2: A read from lane L at a register in quadrant L is local. Its ready is high in the cycle it is requested, unless R8 blocks the port. Its response (rsp_vld high, rsp_data) appears on that port exactly one cycle later.
- R3: Four lanes accessing four consecutive registers, each lane in its own quadrant, are all accepted in the same cycle.
- R4: A write from lane L to a register in quadrant L is always accepted in the cycle it is requested and takes effect at that clock edge.
- R5: Any access to a register outside the lane's own quadrant is remote. Each destination quadrant accepts at most one remote access per cycle. A remote access that is not granted sees ready low.
- R6: Remote requesters aimed at one quadrant are numbered slot = lane*4 + port, where ports 0 to 2 are the reads and port 3 is the write. The grant goes to the first requesting slot at or after a pointer, wrapping around. The pointer starts at 0 and moves to winner+1 after each grant.
- R7: The response to a granted remote read appears on the requesting port exactly two cycles after acceptance.
- R8: In the cycle after a read port is granted a remote read, that port's ready is low, whatever its request.
- R9: While lane Q writes locally, a remote write aimed at quadrant Q is not granted. Remote reads of quadrant Q are still arbitrated as usual.
- R10: A read, local or remote, accepted in the same cycle as an accepted write to the same register returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | NQ*NRP | Read request, one per lane read port (index lane*NRP+port) |
| rd_addr | input | NQ*NRP*AW | Register number per read port |
| rd_ready | output | NQ*NRP | Read accepted this cycle |
| rsp_vld | output | NQ*NRP | Read response valid |
| rsp_data | output | NQ*NRP*DW | Read response data |
| wr_en | input | NQ | Write request per lane |
| wr_addr | input | NQ*AW | Register number per write |
| wr_data | input | NQ*DW | Write data per lane |
| wr_ready | output | NQ | Write accepted this cycle |

## Verification
A wrong arbitration pointer shows up at the ports in the first cycle where two remote requesters compete for one quadrant: rd_ready or wr_ready rises on the wrong lane. A stale busy flag or a misrouted crossbar slot shows one or two cycles after a remote grant, as a missing, doubled or misplaced rsp_vld. A write to the wrong quadrant entry stays hidden until that register is read again, which the random traffic does within a few cycles. A missing forwarding path shows on the very next response when a read and a write of the same register coincide.

// File: rtl/qrf_pkg.sv
package qrf_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE,
    ACC_LOCAL,
    ACC_REMOTE
  } acc_kind_e;

  function automatic int slot_lane(input int s, input int spl);
    return s / spl;
  endfunction

  function automatic int slot_port(input int s, input int spl);
    return s % spl;
  endfunction

  function automatic int rr_next(input int idx, input int n);
    return (idx + 1 == n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/qrf_bank.sv
module qrf_bank #(
  parameter int DW   = 32,
  parameter int NENT = 8,
  parameter int NRD  = 4,
  localparam int EW  = $clog2(NENT)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [EW-1:0]            waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [NRD-1:0][EW-1:0]   raddr,
  output logic [NRD-1:0][DW-1:0]   rdata
);
  logic [DW-1:0] mem [NENT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) mem[e] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // read ports see a write of the same cycle (write-first forwarding)
  always_comb begin
    for (int r = 0; r < NRD; r++) begin
      rdata[r] = (we && waddr == raddr[r]) ? wdata : mem[raddr[r]];
    end
  end
endmodule

// File: rtl/qrf_arb.sv
module qrf_arb import qrf_pkg::*; #(
  parameter int NREQ = 16,
  localparam int IW  = $clog2(NREQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NREQ-1:0]  req,
  output logic [NREQ-1:0]  gnt,
  output logic             gvld,
  output logic [IW-1:0]    gidx
);
  logic [IW-1:0] ptr;

  always_comb begin
    gvld = 1'b0;
    gidx = '0;
    for (int k = 0; k < NREQ; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= NREQ) idx = idx - NREQ;
      if (!gvld && req[idx]) begin
        gvld = 1'b1;
        gidx = IW'(idx);
      end
    end
    gnt = '0;
    if (gvld) gnt[gidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (gvld) ptr <= IW'(rr_next(int'(gidx), NREQ));
  end
endmodule

// File: rtl/qbank_rf.sv
module qbank_rf import qrf_pkg::*; #(
  parameter int NQ   = 4,
  parameter int NRP  = 3,
  parameter int NENT = 8,
  parameter int DW   = 32,
  localparam int QW  = $clog2(NQ),
  localparam int EW  = $clog2(NENT),
  localparam int AW  = QW + EW,
  localparam int NR  = NQ * NRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NR-1:0]     rd_req,
  input  logic [NR*AW-1:0]  rd_addr,
  output logic [NR-1:0]     rd_ready,
  output logic [NR-1:0]     rsp_vld,
  output logic [NR*DW-1:0]  rsp_data,
  input  logic [NQ-1:0]     wr_en,
  input  logic [NQ*AW-1:0]  wr_addr,
  input  logic [NQ*DW-1:0]  wr_data,
  output logic [NQ-1:0]     wr_ready
);
  localparam int SPL = NRP + 1;
  localparam int NS  = NQ * SPL;
  localparam int SW  = $clog2(NS);

  function automatic logic [QW-1:0] quad_of(input logic [AW-1:0] a);
    return a[QW-1:0];
  endfunction

  function automatic logic [EW-1:0] entry_of(input logic [AW-1:0] a);
    return a[AW-1:QW];
  endfunction

  // requester slots: lane*SPL + port, port NRP is the write
  logic [AW-1:0]  s_addr [NS];
  logic [QW-1:0]  s_tq   [NS];
  acc_kind_e      s_kind [NS];
  logic [NS-1:0]  busy;
  logic [NS-1:0]  granted;
  logic [NQ-1:0]  loc_wr;
  logic [NQ-1:0][NS-1:0] req_x, gnt_x;
  logic [NQ-1:0]         gvld_x;
  logic [NQ-1:0][SW-1:0] gidx_x;
  logic [NR-1:0]  loc_rd_acc, rem_rd_gnt;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      int l, p;
      logic want;
      l = slot_lane(s, SPL);
      p = slot_port(s, SPL);
      if (p < NRP) begin
        want      = rd_req[l*NRP+p] & ~busy[s];
        s_addr[s] = rd_addr[(l*NRP+p)*AW +: AW];
      end else begin
        want      = wr_en[l];
        s_addr[s] = wr_addr[l*AW +: AW];
      end
      s_tq[s]   = quad_of(s_addr[s]);
      s_kind[s] = !want ? ACC_IDLE : (s_tq[s] == QW'(l)) ? ACC_LOCAL : ACC_REMOTE;
    end
  end

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      loc_wr[q] = wr_en[q] & (quad_of(wr_addr[q*AW +: AW]) == QW'(q));
      for (int s = 0; s < NS; s++) begin
        req_x[q][s] = (s_kind[s] == ACC_REMOTE) && (s_tq[s] == QW'(q))
                      && !(slot_port(s, SPL) == NRP && loc_wr[q]);
      end
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_arb
    qrf_arb #(.NREQ(NS)) u_arb (
      .clk (clk), .rst_n (rst_n), .req (req_x[q]),
      .gnt (gnt_x[q]), .gvld (gvld_x[q]), .gidx (gidx_x[q])
    );
  end

  always_comb begin
    granted = '0;
    for (int q = 0; q < NQ; q++) granted = granted | gnt_x[q];
  end

  // quadrant banks: NRP local read ports plus one crossbar read port
  logic [NQ-1:0]                   b_we, x_isrd;
  logic [NQ-1:0][EW-1:0]           b_waddr;
  logic [NQ-1:0][DW-1:0]           b_wdata;
  logic [NQ-1:0][SPL-1:0][EW-1:0]  b_raddr;
  logic [NQ-1:0][SPL-1:0][DW-1:0]  bank_rd;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      int gl, gp;
      logic rw;
      gl = slot_lane(int'(gidx_x[q]), SPL);
      gp = slot_port(int'(gidx_x[q]), SPL);
      rw = gvld_x[q] && gp == NRP;
      x_isrd[q]  = gvld_x[q] && gp < NRP;
      b_we[q]    = loc_wr[q] | rw;
      b_waddr[q] = loc_wr[q] ? entry_of(wr_addr[q*AW +: AW]) : entry_of(s_addr[gidx_x[q]]);
      b_wdata[q] = loc_wr[q] ? wr_data[q*DW +: DW] : wr_data[gl*DW +: DW];
      for (int p = 0; p < NRP; p++) b_raddr[q][p] = entry_of(rd_addr[(q*NRP+p)*AW +: AW]);
      b_raddr[q][NRP] = entry_of(s_addr[gidx_x[q]]);
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_bank
    qrf_bank #(.DW(DW), .NENT(NENT), .NRD(SPL)) u_bank (
      .clk (clk), .rst_n (rst_n), .we (b_we[q]), .waddr (b_waddr[q]),
      .wdata (b_wdata[q]), .raddr (b_raddr[q]), .rdata (bank_rd[q])
    );
  end

  // acceptance
  always_comb begin
    for (int s = 0; s < NS; s++) begin
      int l, p;
      logic ok;
      l  = slot_lane(s, SPL);
      p  = slot_port(s, SPL);
      ok = (s_kind[s] == ACC_LOCAL) || (s_kind[s] == ACC_REMOTE && granted[s]);
      if (p < NRP) begin
        rd_ready[l*NRP+p]   = ok;
        loc_rd_acc[l*NRP+p] = (s_kind[s] == ACC_LOCAL);
        rem_rd_gnt[l*NRP+p] = granted[s];
      end else begin
        wr_ready[l] = ok;
      end
    end
  end

  // crossbar stage and response registers
  logic [NQ-1:0]         x_vld;
  logic [NQ-1:0][SW-1:0] x_slot;
  logic [NQ-1:0][DW-1:0] x_data;
  logic [NR-1:0]         nxt_vld;
  logic [NR*DW-1:0]      nxt_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_vld  <= '0;
      x_slot <= '0;
      x_data <= '0;
      busy   <= '0;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        x_vld[q]  <= x_isrd[q];
        x_slot[q] <= gidx_x[q];
        x_data[q] <= bank_rd[q][NRP];
      end
      for (int s = 0; s < NS; s++) busy[s] <= granted[s] && slot_port(s, SPL) < NRP;
    end
  end

  always_comb begin
    for (int l = 0; l < NQ; l++) begin
      for (int p = 0; p < NRP; p++) begin
        nxt_vld[l*NRP+p]             = (s_kind[l*SPL+p] == ACC_LOCAL);
        nxt_data[(l*NRP+p)*DW +: DW] = bank_rd[l][p];
        for (int q = 0; q < NQ; q++) begin
          if (x_vld[q] && x_slot[q] == SW'(l*SPL+p)) begin
            nxt_vld[l*NRP+p]             = 1'b1;
            nxt_data[(l*NRP+p)*DW +: DW] = x_data[q];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld  <= '0;
      rsp_data <= '0;
    end else begin
      rsp_vld  <= nxt_vld;
      rsp_data <= nxt_data;
    end
  end
endmodule

// File: rtl/qrf_chk.sv
module qrf_chk #(
  parameter int NQ  = 4,
  parameter int NRP = 3,
  parameter int SPL = 4,
  parameter int NS  = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NQ-1:0][NS-1:0] req_x,
  input logic [NQ-1:0][NS-1:0] gnt_x,
  input logic [NQ-1:0]         loc_wr,
  input logic [NQ-1:0]         wr_ready,
  input logic [NQ*NRP-1:0]     rd_ready,
  input logic [NQ*NRP-1:0]     rsp_vld,
  input logic [NQ*NRP-1:0]     loc_rd_acc,
  input logic [NQ*NRP-1:0]     rem_rd_gnt
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    // R5
    xbar_one_per_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_x[q]));
    // R5
    grant_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_x[q] & ~req_x[q]) == '0);
    for (genvar l = 0; l < NQ; l++) begin : g_l
      // R9
      local_write_blocks_remote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_wr[q] |-> !gnt_x[q][l*SPL+NRP]);
    end
    // R4
    local_write_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loc_wr[q] |-> wr_ready[q]);
  end

  for (genvar i = 0; i < NQ*NRP; i++) begin : g_rd
    // R2
    local_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loc_rd_acc[i] |=> rsp_vld[i]);
    // R7
    remote_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rem_rd_gnt[i] |=> !rsp_vld[i] ##1 rsp_vld[i]);
    // R8
    remote_busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rem_rd_gnt[i] |=> !rd_ready[i]);
  end
endmodule

bind qbank_rf qrf_chk #(.NQ(NQ), .NRP(NRP), .SPL(SPL), .NS(NS)) u_chk (
  .clk (clk), .rst_n (rst_n), .req_x (req_x), .gnt_x (gnt_x),
  .loc_wr (loc_wr), .wr_ready (wr_ready), .rd_ready (rd_ready),
  .rsp_vld (rsp_vld), .loc_rd_acc (loc_rd_acc), .rem_rd_gnt (rem_rd_gnt)
);

// File: tb/qbank_rf_bench.sv
module qbank_rf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4, NRP = 3, NENT = 8, DW = 32, AW = 5;
  localparam int NR = NQ * NRP, SPL = NRP + 1, NS = NQ * SPL, NREG = NQ * NENT;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NR-1:0] rd_req, rd_ready, rsp_vld;
  logic [NR*AW-1:0] rd_addr;
  logic [NR*DW-1:0] rsp_data;
  logic [NQ-1:0] wr_en, wr_ready;
  logic [NQ*AW-1:0] wr_addr;
  logic [NQ*DW-1:0] wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  qbank_rf u_qbank_rf (
    .clk (clk), .rst_n (rst_n), .rd_req (rd_req), .rd_addr (rd_addr),
    .rd_ready (rd_ready), .rsp_vld (rsp_vld), .rsp_data (rsp_data),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data), .wr_ready (wr_ready)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  string dtag = "";
  logic [DW-1:0] mem [NREG];
  int ptr [NQ];
  bit busy_m [NS];
  bit ea_v [NR], eb_v [NR];
  logic [DW-1:0] ea_d [NR], eb_d [NR];
  string ea_t [NR], eb_t [NR];

  function automatic int quad(input int a); return a % NQ; endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    rd_req = '0; rd_addr = '0; wr_en = '0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic set_rd(input int l, input int p, input int a);
    rd_req[l*NRP+p] = 1'b1;
    rd_addr[(l*NRP+p)*AW +: AW] = AW'(a);
  endtask

  task automatic set_wr(input int l, input int a, input logic [DW-1:0] d);
    wr_en[l] = 1'b1;
    wr_addr[l*AW +: AW] = AW'(a);
    wr_data[l*DW +: DW] = d;
  endtask

  // one cycle: inputs already driven at this negedge
  task automatic step();
    int a [NS], tq [NS], win [NQ], ncont [NQ];
    bit want [NS], rem [NS], elig [NS], grant [NS], acc [NS], locw [NQ];
    #(CLK_PERIOD/4);
    for (int i = 0; i < NR; i++) begin
      chk(rsp_vld[i] == ea_v[i], ea_t[i], $sformatf("rsp_vld[%0d]", i), DW'(rsp_vld[i]), DW'(ea_v[i]));
      if (ea_v[i])
        chk(rsp_data[i*DW +: DW] == ea_d[i], ea_t[i], $sformatf("rsp_data[%0d]", i),
            rsp_data[i*DW +: DW], ea_d[i]);
    end
    for (int q = 0; q < NQ; q++)
      locw[q] = wr_en[q] && quad(int'(wr_addr[q*AW +: AW])) == q;
    for (int s = 0; s < NS; s++) begin
      int l = s / SPL, p = s % SPL;
      if (p < NRP) begin
        want[s] = rd_req[l*NRP+p] && !busy_m[s];
        a[s] = int'(rd_addr[(l*NRP+p)*AW +: AW]);
      end else begin
        want[s] = wr_en[l];
        a[s] = int'(wr_addr[l*AW +: AW]);
      end
      tq[s] = quad(a[s]);
      rem[s] = tq[s] != l;
      elig[s] = want[s] && rem[s] && (p < NRP || !locw[tq[s]]);
    end
    for (int q = 0; q < NQ; q++) begin
      win[q] = -1; ncont[q] = 0;
      for (int k = 0; k < NS; k++) begin
        int s = (ptr[q] + k) % NS;
        if (elig[s] && tq[s] == q) begin
          ncont[q]++;
          if (win[q] < 0) win[q] = s;
        end
      end
    end
    for (int s = 0; s < NS; s++) begin
      int l = s / SPL, p = s % SPL;
      string tg;
      logic act;
      grant[s] = elig[s] && win[tq[s]] == s;
      acc[s] = want[s] && (!rem[s] || grant[s]);
      if (p < NRP) begin
        act = rd_ready[l*NRP+p];
        tg = (rd_req[l*NRP+p] && busy_m[s]) ? "R8" : !rem[s] ? "R2" : ncont[tq[s]] > 1 ? "R6" : "R5";
      end else begin
        act = wr_ready[l];
        tg = !rem[s] ? "R4" : locw[tq[s]] ? "R9" : ncont[tq[s]] > 1 ? "R6" : "R5";
      end
      chk(act == acc[s], tg, $sformatf("ready slot %0d", s), DW'(act), DW'(acc[s]));
    end
    for (int i = 0; i < NR; i++) begin
      ea_v[i] = eb_v[i]; ea_d[i] = eb_d[i]; ea_t[i] = eb_t[i]; eb_v[i] = 0;
    end
    for (int s = 0; s < NS; s++) begin
      int l = s / SPL, p = s % SPL;
      if (p < NRP && acc[s]) begin
        logic [DW-1:0] v = mem[a[s]];
        bit fwd = 0;
        for (int w = 0; w < NQ; w++)
          if (acc[w*SPL+NRP] && a[w*SPL+NRP] == a[s]) begin
            v = wr_data[w*DW +: DW]; fwd = 1;
          end
        if (rem[s]) begin
          eb_v[l*NRP+p] = 1; eb_d[l*NRP+p] = v; eb_t[l*NRP+p] = fwd ? "R10" : "R7";
        end else begin
          ea_v[l*NRP+p] = 1; ea_d[l*NRP+p] = v;
          ea_t[l*NRP+p] = dtag != "" ? dtag : fwd ? "R10" : "R2";
        end
      end
    end
    for (int w = 0; w < NQ; w++)
      if (acc[w*SPL+NRP]) mem[a[w*SPL+NRP]] = wr_data[w*DW +: DW];
    for (int q = 0; q < NQ; q++)
      if (win[q] >= 0) ptr[q] = (win[q] + 1) % NS;
    for (int s = 0; s < NS; s++) busy_m[s] = grant[s] && (s % SPL) < NRP;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < NREG; r++) mem[r] = '0;
    for (int q = 0; q < NQ; q++) ptr[q] = 0;
    for (int s = 0; s < NS; s++) busy_m[s] = 0;
    for (int i = 0; i < NR; i++) begin ea_v[i] = 0; eb_v[i] = 0; ea_t[i] = "R1"; eb_t[i] = "R1"; end
    clear_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: every entry reads zero after reset, decode by low bits
    dtag = "R1";
    for (int r = 0; r < 3; r++) begin
      clear_inputs();
      for (int l = 0; l < NQ; l++)
        for (int p = 0; p < NRP; p++) set_rd(l, p, l + NQ * ((r * NRP + p) % NENT));
      step();
    end
    dtag = "";
    // R3: four neighbouring registers, four lanes, one cycle
    clear_inputs();
    for (int l = 0; l < NQ; l++) set_wr(l, 8 + l, 32'hA500_0000 + l);
    #1 chk($countones(wr_ready) == NQ, "R3", "parallel writes", DW'($countones(wr_ready)), NQ);
    step();
    clear_inputs();
    for (int l = 0; l < NQ; l++) set_rd(l, 0, 8 + l);
    #1 chk($countones(rd_ready) == NQ, "R3", "parallel reads", DW'($countones(rd_ready)), NQ);
    step();
    // R5 R6 R7 R8: three lanes hammer quadrant 0
    for (int c = 0; c < 6; c++) begin
      clear_inputs();
      for (int l = 1; l < NQ; l++) set_rd(l, 0, 4 * l);
      set_rd(1, 1, 8);
      set_wr(2, 20, 32'hBEE0_0000 + c);
      #1 chk($countones(rd_ready) + $countones(wr_ready) <= 1, "R5", "one per dest",
             DW'($countones(rd_ready) + $countones(wr_ready)), 1);
      step();
    end
    // R9: local write masks remote write to same quadrant
    clear_inputs();
    set_wr(0, 12, 32'h1111_0000);
    set_wr(1, 16, 32'h2222_0000);
    #1 chk(wr_ready[1] == 1'b0, "R9", "remote write masked", DW'(wr_ready[1]), 0);
    step();
    // R10: write and reads of the same register together
    clear_inputs();
    set_wr(2, 6, 32'hF0F0_1234);
    set_rd(2, 0, 6);
    set_rd(1, 0, 6);
    step();
    clear_inputs();
    step();
    step();
    // random traffic
    for (int c = 0; c < 3000; c++) begin
      clear_inputs();
      for (int i = 0; i < NR; i++) begin
        int l = i / NRP;
        if ($urandom % 2 == 0)
          set_rd(l, i % NRP, ($urandom % 2 == 0) ? l + NQ * int'($urandom % NENT) : int'($urandom % NREG));
      end
      for (int l = 0; l < NQ; l++)
        if ($urandom % 3 == 0)
          set_wr(l, ($urandom % 2 == 0) ? l + NQ * int'($urandom % NENT) : int'($urandom % NREG), $urandom);
      step();
    end
    clear_inputs();
    repeat (3) step();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule